// File: doc/BRIEF.md
# Segment Address Translation Unit

The unit turns a logical address into a linear address. A logical address is a 16-bit segment selector plus a 32-bit offset. The selector picks a descriptor from either the global or the local descriptor table, whose base addresses come in as inputs. The unit fetches that descriptor as two 32-bit words over a simple read port. It then checks presence, limit, access type and privilege. If every check passes, it returns the descriptor base plus the offset. If a check fails, it returns a 2-bit fault code.

A request is a one-cycle `req_valid` pulse carrying the selector, the offset, the access kind and the current privilege level. The unit is busy until it raises `done` for exactly one cycle with the result. Requests that arrive while it is busy are dropped.

Selector layout:

| Bits | Field |
|------|-------|
| [1:0] | requested level |
| [2] | table choice (0 = global, 1 = local) |
| [15:3] | descriptor index |

Descriptor word 0 (at the lower address) is the 32-bit segment base. Descriptor word 1 (at +4) is laid out as follows:

| Bits | Field |
|------|-------|
| [19:0] | limit |
| [20] | granularity |
| [21] | present |
| [23:22] | descriptor level |
| [24] | permit (write for data, read for code) |
| [25] | code |

Access kinds are 00 read, 01 write, 10 execute and 11 reserved.

Top module: `seg_xlate`

## Requirements
- R1: The table base is `gdt_base` when selector bit 2 is 0 and `ldt_base` when it is 1. The descriptor is read at table base + index*8, then at that address + 4, in that order. Word 0 is the segment base and word 1 holds the attributes.
- R2: A global selector with index 0 completes with fault and code 00 and makes no memory read. A local selector with index 0 is fetched normally.
- R3: A descriptor whose present bit is 0 completes with fault code 01.
- R4: The effective limit is {limit, 12'hFFF} when granularity is 1 and the zero-extended limit when it is 0. An offset greater than the effective limit completes with fault code 10. An offset equal to it passes.
- R5: Type rule, with fault code 11 on violation. Execute needs code=1. Write needs code=0 and permit=1. Read needs code=0 or permit=1. The reserved access kind always violates.
- R6: Privilege rule. The effective level is max(cpl, requested level). If it is numerically greater than the descriptor level, the request completes with fault code 11.
- R7: When no check fails, `fault` is 0, `fault_code` is 00 and `lin_addr` equals base + offset modulo 2^32.
- R8: Fault priority is null selector, then not present (01), then limit (10), then type or privilege (11).
- R9: `done` is high for exactly one cycle per accepted request. `lin_addr` is 0 whenever `fault` is 1.
- R10: `mem_rd` and `mem_addr` hold steady until `mem_rvalid`. A `req_valid` pulse while `busy` is 1 is ignored and produces no extra `done`.
- R11: After reset, `busy`, `done` and `mem_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request pulse |
| req_sel | input | 16 | segment selector |
| req_off | input | 32 | offset |
| req_acc | input | 2 | access kind |
| cpl | input | 2 | current privilege level |
| gdt_base | input | 32 | global table start |
| ldt_base | input | 32 | local table start |
| mem_rd | output | 1 | descriptor read request |
| mem_addr | output | 32 | descriptor word address |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | 32 | read data |
| busy | output | 1 | translation in progress |
| done | output | 1 | result strobe |
| fault | output | 1 | translation refused |
| fault_code | output | 2 | fault reason |
| lin_addr | output | 32 | linear address |

## Verification
A wrongly latched table base or index shows up in the very next read, as a bad `mem_addr`. The bench records each fetch address and compares it. A stale or wrongly captured descriptor word is only visible at `done`. At that point it gives a wrong sum or a fault code that does not match the stimulus, so the checks use descriptors whose fields differ from those of neighbouring tests. A state machine that skips or repeats a state shows up as an extra or missing read, or as a `done` that fails to pulse once.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [15:0]   req_sel,
  input  logic [AW-1:0] req_off,
  input  logic [1:0]    req_acc,
  input  logic [1:0]    cpl,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code,
  output logic [AW-1:0] lin_addr
);
  localparam logic [1:0] S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_FIN = 2'd3;

  logic [1:0]    st;
  logic [AW-1:0] tbase_q, off_q, base_q;
  logic [12:0]   idx_q;
  logic [1:0]    acc_q, lvl_q;
  logic          null_q;
  logic [31:0]   attr_q;

  wire [1:0] rpl     = req_sel[1:0];
  wire       is_null = !req_sel[2] && (req_sel[15:3] == 13'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tbase_q <= '0;
      off_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      lvl_q   <= '0;
      null_q  <= 1'b0;
      attr_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          tbase_q <= req_sel[2] ? ldt_base : gdt_base;
          idx_q   <= req_sel[15:3];
          off_q   <= req_off;
          acc_q   <= req_acc;
          lvl_q   <= (cpl > rpl) ? cpl : rpl;
          null_q  <= is_null;
          st      <= is_null ? S_FIN : S_LO;
        end
        S_LO: if (mem_rvalid) begin
          base_q <= mem_rdata[AW-1:0];
          st     <= S_HI;
        end
        S_HI: if (mem_rvalid) begin
          attr_q <= mem_rdata;
          st     <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign mem_rd   = (st == S_LO) || (st == S_HI);
  assign mem_addr = tbase_q + {{(AW-16){1'b0}}, idx_q, 3'b000}
                  + ((st == S_HI) ? AW'(4) : AW'(0));

  wire [19:0]   lim   = attr_q[19:0];
  wire          gran  = attr_q[20];
  wire          pres  = attr_q[21];
  wire [1:0]    dpl   = attr_q[23:22];
  wire          perm  = attr_q[24];
  wire          code  = attr_q[25];
  wire [AW-1:0] elim  = gran ? AW'({lim, 12'hFFF}) : AW'(lim);

  logic type_bad;
  always_comb begin
    case (acc_q)
      2'b00:   type_bad = code && !perm;
      2'b01:   type_bad = code || !perm;
      2'b10:   type_bad = !code;
      default: type_bad = 1'b1;
    endcase
  end

  wire over     = off_q > elim;
  wire priv_bad = lvl_q > dpl;

  logic       bad;
  logic [1:0] why;
  always_comb begin
    bad = 1'b1;
    if (null_q)                    why = 2'b00;
    else if (!pres)                why = 2'b01;
    else if (over)                 why = 2'b10;
    else if (type_bad || priv_bad) why = 2'b11;
    else begin
      why = 2'b00;
      bad = 1'b0;
    end
  end

  assign fault      = done && bad;
  assign fault_code = done ? why : 2'b00;
  assign lin_addr   = (done && !bad) ? base_q + off_q : '0;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [1:0]    fault_code,
  input logic [AW-1:0] lin_addr
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fault_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (lin_addr == '0));
  assert_ok_code_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (fault_code == 2'b00));
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !done));
  assert_word_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd && mem_rvalid) && mem_rd) |-> (mem_addr == $past(mem_addr) + AW'(4)));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [15:0] req_sel = 0;
  logic [31:0] req_off = 0;
  logic [1:0] req_acc = 0, cpl = 0;
  logic [31:0] gdt_base = 32'h0, ldt_base = 32'h80;
  logic mem_rd, mem_rvalid, busy, done, fault;
  logic [31:0] mem_addr, mem_rdata, lin_addr;
  logic [1:0] fault_code;

  always #10 clk = ~clk;

  seg_xlate u0 (.*);

  logic [31:0] mem [0:63];
  int lat = 0, cnt = 0, nreads = 0, ndone = 0;
  logic [31:0] rd_addr [0:3];
  int checks = 0, fails = 0;
  logic r_fault; logic [1:0] r_code; logic [31:0] r_lin;

  assign mem_rdata  = mem[mem_addr[7:2]];
  assign mem_rvalid = mem_rd && (cnt >= lat);

  always @(posedge clk) begin
    if (mem_rd && !mem_rvalid) cnt <= cnt + 1; else cnt <= 0;
    if (mem_rd && mem_rvalid) begin
      rd_addr[nreads % 4] <= mem_addr;
      nreads <= nreads + 1;
    end
    if (done) ndone <= ndone + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w1(input logic [19:0] lim, input bit g, input bit p,
                                     input logic [1:0] dpl, input bit perm, input bit code);
    return {6'd0, code, perm, dpl, p, g, lim};
  endfunction

  task automatic put(input logic [31:0] tb, input int idx, input logic [31:0] b, input logic [31:0] a);
    mem[(tb + idx*8) >> 2]       = b;
    mem[((tb + idx*8) >> 2) + 1] = a;
  endtask

  task automatic xlate(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] acc, input logic [1:0] lv);
    int n = 0;
    @(negedge clk);
    nreads = 0;
    req_sel = sel; req_off = off; req_acc = acc; cpl = lv; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) begin checks++; fails++; $display("FAIL timeout waiting for done"); end
    r_fault = fault; r_code = fault_code; r_lin = lin_addr;
    @(negedge clk);
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] exp);
    chk(!r_fault, tag, {31'd0, r_fault}, 32'd0);
    chk(r_lin == exp, tag, r_lin, exp);
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] code);
    chk(r_fault, tag, {31'd0, r_fault}, 32'd1);
    chk(r_code == code, tag, {30'd0, r_code}, {30'd0, code});
    chk(r_lin == 0, {tag, " R9 addr zero"}, r_lin, 32'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_rd, "R11 reset idle", {29'd0, busy, done, mem_rd}, 32'd0);
  endtask

  task automatic t_table_select;
    put(32'h0, 3, 32'h1000_0000, w1(20'hFFFFF, 0, 1, 3, 1, 0));
    put(32'h80, 3, 32'h2000_0000, w1(20'hFFFFF, 0, 1, 3, 1, 0));
    xlate({13'd3, 1'b0, 2'd0}, 32'h10, 2'b00, 0);
    chk(nreads == 2 && rd_addr[0] == 32'h18 && rd_addr[1] == 32'h1C, "R1 global fetch addr", rd_addr[0], 32'h18);
    expect_ok("R7 global sum", 32'h1000_0010);
    xlate({13'd3, 1'b1, 2'd0}, 32'h10, 2'b00, 0);
    chk(rd_addr[0] == 32'h98 && rd_addr[1] == 32'h9C, "R1 local fetch addr", rd_addr[0], 32'h98);
    expect_ok("R7 local sum", 32'h2000_0010);
  endtask

  task automatic t_null;
    xlate({13'd0, 1'b0, 2'd2}, 32'h0, 2'b00, 0);
    chk(nreads == 0, "R2 null no read", nreads, 0);
    expect_fault("R2 null", 2'b00);
    put(32'h80, 0, 32'h0000_4000, w1(20'h0FFFF, 0, 1, 0, 1, 0));
    xlate({13'd0, 1'b1, 2'd0}, 32'h5, 2'b01, 0);
    chk(nreads == 2 && rd_addr[0] == 32'h80, "R2 local index 0 fetched", rd_addr[0], 32'h80);
    expect_ok("R2 local index 0", 32'h4005);
  endtask

  task automatic t_present;
    put(32'h0, 1, 32'h5000, w1(20'hFFFFF, 1, 0, 3, 1, 0));
    xlate({13'd1, 1'b0, 2'd0}, 32'h4, 2'b00, 0);
    expect_fault("R3 not present", 2'b01);
  endtask

  task automatic t_limit;
    put(32'h0, 2, 32'h6000, w1(20'h00100, 0, 1, 3, 1, 0));
    xlate({13'd2, 1'b0, 2'd0}, 32'h100, 2'b00, 0);
    expect_ok("R4 byte limit equal", 32'h6100);
    xlate({13'd2, 1'b0, 2'd0}, 32'h101, 2'b00, 0);
    expect_fault("R4 byte limit over", 2'b10);
    put(32'h0, 4, 32'h0, w1(20'h00002, 1, 1, 3, 1, 0));
    xlate({13'd4, 1'b0, 2'd0}, 32'h2FFF, 2'b00, 0);
    expect_ok("R4 page limit equal", 32'h2FFF);
    xlate({13'd4, 1'b0, 2'd0}, 32'h3000, 2'b00, 0);
    expect_fault("R4 page limit over", 2'b10);
  endtask

  task automatic t_type;
    put(32'h0, 5, 32'h7000, w1(20'hFFFFF, 0, 1, 3, 0, 0));
    xlate({13'd5, 1'b0, 2'd0}, 32'h8, 2'b01, 0);
    expect_fault("R5 write read-only", 2'b11);
    xlate({13'd5, 1'b0, 2'd0}, 32'h8, 2'b00, 0);
    expect_ok("R5 read read-only", 32'h7008);
    xlate({13'd5, 1'b0, 2'd0}, 32'h8, 2'b10, 0);
    expect_fault("R5 exec data", 2'b11);
    put(32'h0, 6, 32'h8000, w1(20'hFFFFF, 0, 1, 3, 0, 1));
    xlate({13'd6, 1'b0, 2'd0}, 32'h8, 2'b10, 0);
    expect_ok("R5 exec code", 32'h8008);
    xlate({13'd6, 1'b0, 2'd0}, 32'h8, 2'b00, 0);
    expect_fault("R5 read exec-only", 2'b11);
    xlate({13'd6, 1'b0, 2'd0}, 32'h8, 2'b11, 0);
    expect_fault("R5 reserved kind", 2'b11);
  endtask

  task automatic t_priv;
    put(32'h0, 7, 32'h9000, w1(20'hFFFFF, 0, 1, 2, 1, 0));
    xlate({13'd7, 1'b0, 2'd3}, 32'h1, 2'b00, 0);
    expect_fault("R6 rpl above dpl", 2'b11);
    xlate({13'd7, 1'b0, 2'd0}, 32'h1, 2'b00, 3);
    expect_fault("R6 cpl above dpl", 2'b11);
    xlate({13'd7, 1'b0, 2'd2}, 32'h1, 2'b00, 1);
    expect_ok("R6 level equal dpl", 32'h9001);
  endtask

  task automatic t_priority;
    put(32'h80, 1, 32'h0, w1(20'h00010, 0, 0, 0, 0, 0));
    xlate({13'd1, 1'b1, 2'd3}, 32'h100, 2'b01, 3);
    expect_fault("R8 not present wins", 2'b01);
    put(32'h80, 2, 32'h0, w1(20'h00010, 0, 1, 0, 0, 0));
    xlate({13'd2, 1'b1, 2'd3}, 32'h100, 2'b01, 3);
    expect_fault("R8 limit over protection", 2'b10);
  endtask

  task automatic t_wrap;
    put(32'h80, 4, 32'hFFFF_F000, w1(20'hFFFFF, 1, 1, 3, 1, 0));
    xlate({13'd4, 1'b1, 2'd0}, 32'h2000, 2'b01, 0);
    expect_ok("R7 wrap sum", 32'h0000_1000);
  endtask

  task automatic t_slow_busy;
    int d0, n = 0;
    lat = 3;
    d0 = ndone;
    @(negedge clk);
    nreads = 0;
    req_sel = {13'd3, 1'b0, 2'd0}; req_off = 32'h44; req_acc = 0; cpl = 0; req_valid = 1;
    @(negedge clk);
    req_sel = {13'd3, 1'b1, 2'd0}; req_off = 32'h99;
    @(negedge clk);
    req_valid = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(!fault && lin_addr == 32'h1000_0044, "R10 busy request ignored", lin_addr, 32'h1000_0044);
    chk(rd_addr[1] == 32'h1C, "R10 slow read addr", rd_addr[1], 32'h1C);
    repeat (20) @(negedge clk);
    chk(ndone - d0 == 1, "R9 one done per request", ndone - d0, 1);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_table_select();
    t_null();
    t_present();
    t_limit();
    t_type();
    t_priv();
    t_priority();
    t_wrap();
    t_slow_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule